// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This block produces two pulse-width-modulated outputs, each from its own 8-bit period counter. A 32-bit register port with write strobe, byte address and combinational read data reaches one shared control word and one timing word per channel. In the control word each channel has a field for the clock divider code, the run controls and the output polarity. A 4-bit divider code picks the ratio from a fixed table of sparse, non-power-of-two ratios. That table also has reserved codes and a pass-through code.

A timing word holds the number of active counts and the period length minus one. An accepted write goes into a shadow copy and raises the channel's busy flag. The counter takes the shadow values at its next wrap, or on the next clock while the channel is stopped, and the flag drops at that moment. While the flag is set, further writes to that timing word are dropped. Software reads the busy flags in the control word.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset the control word and both timing words read 0, and both outputs are 1 (the polarity bit resets to 0, which means active-low).
- R2: Channel n's control field sits at bit 15*n: bits 3:0 divider code, 4 run enable, 5 polarity (1 = active-high, 0 = active-low), 6 clock gate, 7/8/9 stored-only mode, pulse and pass bits. The busy flag of channel n reads at bit 28+n. All other control bits read 0.
- R3: The timing word of channel n is at byte address 4+4*n. Bits 7:0 hold the active count and bits 23:16 hold the period minus one. A read returns the last accepted value with the other bits at 0. Other addresses read 0 and a write to them changes nothing.
- R4: With divider code 15 (ratio 1) the counter value k edges after the run-start edge is k mod (period+1). The output is at the active level while the counter is below the active count and at the inactive level otherwise.
- R5: An active count of 0 gives a constant inactive output. An active count at or above period+1 gives a constant active output.
- R6: A channel runs only while both the enable bit and the gate bit are 1. Otherwise its output sits at the inactive level, and on restart its counter begins again at 0.
- R7: Codes 0,1,2,3,4,8,9,10,11,12,15 divide by 120,180,240,360,480,12000,24000,36000,48000,72000,1. The counter steps once every ratio clocks, first at edge ratio after the run-start edge.
- R8: Under a reserved code (5-7, 13, 14) the counter holds and the output is inactive. Going back to a valid code resumes counting from the held value.
- R9: An accepted timing write sets the busy flag from the next cycle. A running channel takes the new values at its wrap edge, and the flag clears at that edge. A stopped channel takes them at the next edge.
- R10: A timing write while that channel's busy flag is set has no effect.
- R11: A timing write on a wrap edge is accepted and stays pending until the following wrap. The wrap on that edge reloads the previous values.
- R12: Each channel's waveform depends only on its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | Modulated outputs |

## Verification
Two events can fall on the same edge: a timing-word write and the counter wrap that consumes pending values. The bench aims a write at a wrap edge. It then checks that the waveform keeps the old duty for one more period, that the busy flag stays set across that period, and that the new duty appears only at the following wrap. A second case lands a dropped write while the flag is still set. There the bench checks that the wrap which clears the flag loads the first value and not the dropped one.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
   localparam int CNT_W        = 8;
   localparam int CFG_W        = 10;
   localparam int FIELD_STRIDE = 15;
   localparam int BUSY_BASE    = 28;
   localparam int RATIO_W      = 17;
   localparam int SH_W         = 2 * CNT_W;

   typedef struct packed {
      logic       pass_bit;
      logic       pulse_bit;
      logic       mode_bit;
      logic       gate;
      logic       level;
      logic       en;
      logic [3:0] code;
   } chan_cfg_t;

   // divider ratio per code; 0 marks a reserved code
   function automatic logic [RATIO_W-1:0] div_ratio(input logic [3:0] code);
      logic [RATIO_W-1:0] r;
      case (code)
         4'd0:    r = RATIO_W'(120);
         4'd1:    r = RATIO_W'(180);
         4'd2:    r = RATIO_W'(240);
         4'd3:    r = RATIO_W'(360);
         4'd4:    r = RATIO_W'(480);
         4'd8:    r = RATIO_W'(12000);
         4'd9:    r = RATIO_W'(24000);
         4'd10:   r = RATIO_W'(36000);
         4'd11:   r = RATIO_W'(48000);
         4'd12:   r = RATIO_W'(72000);
         4'd15:   r = RATIO_W'(1);
         default: r = '0;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/pwm2_prescale.sv
module pwm2_prescale
   import pwm2_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               adv,
   input  logic [RATIO_W-1:0] ratio,
   output logic               tick
);
   logic [RATIO_W-1:0] pc_q;
   logic               at_end;

   assign at_end = (pc_q == ratio - RATIO_W'(1));
   assign tick   = adv && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= '0;
      else if (clr)     pc_q <= '0;
      else if (adv)     pc_q <= at_end ? '0 : pc_q + RATIO_W'(1);
   end
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
   import pwm2_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       code,
   input  logic             en,
   input  logic             gate,
   input  logic             level,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_act,
   input  logic [CNT_W-1:0] wr_prd,
   output logic             busy_o,
   output logic [SH_W-1:0]  shadow_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             bound_o,
   output logic             run_o,
   output logic             rsv_o,
   output logic             pwm_o
);
   logic [RATIO_W-1:0] ratio;
   logic               run, rsv, adv, tick, bound, reload, accept;
   logic [CNT_W-1:0]   sh_act, sh_prd, act_q, prd_q, cnt_q;
   logic               busy_q;

   assign ratio  = div_ratio(code);
   assign run    = en & gate;
   assign rsv    = (ratio == '0);
   assign adv    = run & ~rsv;
   assign bound  = tick && (cnt_q == prd_q);
   assign reload = bound || !run;
   assign accept = wr && !busy_q;

   pwm2_prescale u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!run),
      .adv   (adv),
      .ratio (ratio),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_act <= '0;
         sh_prd <= '0;
         act_q  <= '0;
         prd_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else begin
         if (accept) begin
            sh_act <= wr_act;
            sh_prd <= wr_prd;
         end
         if (accept)      busy_q <= 1'b1;
         else if (reload) busy_q <= 1'b0;
         if (reload) begin
            act_q <= sh_act;
            prd_q <= sh_prd;
         end
         if (!run)        cnt_q <= '0;
         else if (tick)   cnt_q <= bound ? '0 : cnt_q + CNT_W'(1);
      end
   end

   assign pwm_o    = (adv && (cnt_q < act_q)) ? level : ~level;
   assign busy_o   = busy_q;
   assign shadow_o = {sh_prd, sh_act};
   assign cnt_o    = cnt_q;
   assign bound_o  = bound;
   assign run_o    = run;
   assign rsv_o    = rsv;
endmodule

// File: rtl/pwm2_regs.sv
module pwm2_regs
   import pwm2_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [NCH-1:0]    busy,
   input  logic [NCH*SH_W-1:0] shadow,
   output logic [NCH*4-1:0]  code_o,
   output logic [NCH-1:0]    en_o,
   output logic [NCH-1:0]    gate_o,
   output logic [NCH-1:0]    lvl_o,
   output logic [NCH-1:0]    wr_o,
   output logic [CNT_W-1:0]  wr_act,
   output logic [CNT_W-1:0]  wr_prd,
   output logic [31:0]       rdata
);
   localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

   chan_cfg_t [NCH-1:0] cfg_q;
   logic                unused_wdata;

   assign unused_wdata = ^wdata;
   assign wr_act       = wdata[CNT_W-1:0];
   assign wr_prd       = wdata[16 +: CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we && addr == CTRL_ADDR) begin
         for (int n = 0; n < NCH; n++)
            cfg_q[n] <= wdata[n*FIELD_STRIDE +: CFG_W];
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_dec
      assign wr_o[n]          = we && (addr == ADDR_W'(4 + 4*n));
      assign code_o[n*4 +: 4] = cfg_q[n].code;
      assign en_o[n]          = cfg_q[n].en;
      assign gate_o[n]        = cfg_q[n].gate;
      assign lvl_o[n]         = cfg_q[n].level;
   end

   always_comb begin
      rdata = '0;
      if (addr == CTRL_ADDR) begin
         for (int n = 0; n < NCH; n++) begin
            rdata[n*FIELD_STRIDE +: CFG_W] = cfg_q[n];
            rdata[BUSY_BASE + n]           = busy[n];
         end
      end else begin
         for (int n = 0; n < NCH; n++) begin
            if (addr == ADDR_W'(4 + 4*n)) begin
               rdata[CNT_W-1:0]   = shadow[n*SH_W +: CNT_W];
               rdata[16 +: CNT_W] = shadow[n*SH_W + CNT_W +: CNT_W];
            end
         end
      end
   end
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
   import pwm2_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NCH-1:0]    pwm_out
);
   if (NCH < 1 || NCH > 2) begin : g_bad_nch
      $error("pwm2_ctrl: NCH must be 1 or 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("pwm2_ctrl: ADDR_W must reach the last timing word");
   end

   logic [NCH*4-1:0]    code_v;
   logic [NCH-1:0]      en_v, gate_v, lvl_v, wr_v;
   logic [NCH-1:0]      busy_v, bound_v, run_v, rsv_v;
   logic [NCH*SH_W-1:0] shadow_v;
   logic [NCH*CNT_W-1:0] cnt_v;
   logic [CNT_W-1:0]    wr_act, wr_prd;

   pwm2_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .busy   (busy_v),
      .shadow (shadow_v),
      .code_o (code_v),
      .en_o   (en_v),
      .gate_o (gate_v),
      .lvl_o  (lvl_v),
      .wr_o   (wr_v),
      .wr_act (wr_act),
      .wr_prd (wr_prd),
      .rdata  (bus_rdata)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      pwm2_channel u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .code     (code_v[n*4 +: 4]),
         .en       (en_v[n]),
         .gate     (gate_v[n]),
         .level    (lvl_v[n]),
         .wr       (wr_v[n]),
         .wr_act   (wr_act),
         .wr_prd   (wr_prd),
         .busy_o   (busy_v[n]),
         .shadow_o (shadow_v[n*SH_W +: SH_W]),
         .cnt_o    (cnt_v[n*CNT_W +: CNT_W]),
         .bound_o  (bound_v[n]),
         .run_o    (run_v[n]),
         .rsv_o    (rsv_v[n]),
         .pwm_o    (pwm_out[n])
      );
   end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk
   import pwm2_pkg::*;
#(
   parameter int NCH = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NCH-1:0]       pwm_out,
   input logic [NCH-1:0]       lvl_v,
   input logic [NCH-1:0]       run_v,
   input logic [NCH-1:0]       rsv_v,
   input logic [NCH-1:0]       busy_v,
   input logic [NCH-1:0]       bound_v,
   input logic [NCH-1:0]       wr_v,
   input logic [NCH*SH_W-1:0]  shadow_v,
   input logic [NCH*CNT_W-1:0] cnt_v
);
   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R6: stopped channel sits at inactive level
      a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !run_v[i] |-> pwm_out[i] == ~lvl_v[i]);
      // R8: reserved code gives inactive level
      a_r8_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
         rsv_v[i] |-> pwm_out[i] == ~lvl_v[i]);
      // R8: reserved code freezes the counter
      a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (run_v[i] && rsv_v[i] && $past(run_v[i] && rsv_v[i]))
            |-> $stable(cnt_v[i*CNT_W +: CNT_W]));
      // R9: accepted write raises busy
      a_r9_write_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_v[i] && !busy_v[i]) |=> busy_v[i]);
      // R9: busy drops only at a wrap or while stopped
      a_r9_clear_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(busy_v[i]) |-> $past(bound_v[i] || !run_v[i]));
      // R10: write while busy leaves the shadow alone
      a_r10_busy_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_v[i] && busy_v[i]) |=> $stable(shadow_v[i*SH_W +: SH_W]));
   end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_out  (pwm_out),
   .lvl_v    (lvl_v),
   .run_v    (run_v),
   .rsv_v    (rsv_v),
   .busy_v   (busy_v),
   .bound_v  (bound_v),
   .wr_v     (wr_v),
   .shadow_v (shadow_v),
   .cnt_v    (cnt_v)
);

// File: tb/pwm2_ctrl_bench.sv
module pwm2_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  pwm_out;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm2_ctrl #(.NCH(2), .ADDR_W(4)) u_pwm2_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; write lands on the next posedge; returns at the following negedge
   task automatic bw(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = '0;
   endtask

   task automatic br(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] cw(input int code, input bit en, input bit gate, input bit lvl);
      return {22'd0, 1'b0, gate, lvl, en, 4'(code)};
   endfunction

   function automatic logic [31:0] per(input int prd, input int act);
      return {8'd0, 8'(prd), 8'd0, 8'(act)};
   endfunction

   function automatic logic exp_out(input int k, input int r, input int p, input int a, input bit l);
      int c;
      c = (k / r) % (p + 1);
      return (c < a) ? l : ~l;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int codes [7] = '{0, 1, 2, 3, 4, 8, 9};
      int ratios[7] = '{120, 180, 240, 360, 480, 12000, 24000};

      repeat (3) @(negedge clk);
      // R1 reset state
      chk({30'd0, pwm_out}, 32'd3, "R1 idle outputs");
      br(4'h0, rd); chk(rd, 32'd0, "R1 control word");
      br(4'h4, rd); chk(rd, 32'd0, "R1 timing ch0");
      br(4'h8, rd); chk(rd, 32'd0, "R1 timing ch1");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 control readback
      bw(4'h0, 32'hFFFF_FFFF);
      br(4'h0, rd); chk(rd, 32'h01FF_83FF, "R2 control mask");
      bw(4'h0, 32'h0);
      br(4'h0, rd); chk(rd, 32'h0, "R2 control cleared");

      // R3 / R9 timing layout, stopped-channel load
      bw(4'h8, 32'hFFFF_FFFF);
      br(4'h0, rd); chk(rd, 32'h2000_0000, "R9 busy ch1 after write");
      @(negedge clk);
      br(4'h0, rd); chk(rd, 32'h0, "R9 stopped load clears busy");
      br(4'h8, rd); chk(rd, 32'h00FF_00FF, "R3 timing ch1 readback");
      bw(4'hC, 32'h1234_5678);
      br(4'hC, rd); chk(rd, 32'h0, "R3 unmapped read");
      br(4'h8, rd); chk(rd, 32'h00FF_00FF, "R3 unmapped write no effect ch1");
      br(4'h4, rd); chk(rd, 32'h0, "R3 unmapped write no effect ch0");
      br(4'h0, rd); chk(rd, 32'h0, "R3 unmapped write no effect ctrl");

      // R4 R5 R12 sweep, ratio 1
      for (int p = 0; p < 6; p++) begin
         for (int a = 0; a <= p + 2; a++) begin
            for (int l = 0; l < 2; l++) begin
               bw(4'h0, 32'h0);
               bw(4'h4, per(p, a));
               bw(4'h8, per(2, a % 4));
               bw(4'h0, cw(15, 1, 1, l[0]) | (cw(15, 1, 1, !l[0]) << 15));
               for (int k = 0; k < 2*(p+1) + 2; k++) begin
                  if (a == 0 || a > p)
                     chk({31'd0, pwm_out[0]}, {31'd0, exp_out(k, 1, p, a, l[0])}, "R5 ch0 edge duty");
                  else
                     chk({31'd0, pwm_out[0]}, {31'd0, exp_out(k, 1, p, a, l[0])}, "R4 ch0 waveform");
                  chk({31'd0, pwm_out[1]}, {31'd0, exp_out(k, 1, 2, a % 4, !l[0])}, "R12 ch1 independent");
                  @(negedge clk);
               end
            end
         end
      end

      // R6 stop via gate and enable, restart from zero
      bw(4'h0, 32'h0);
      bw(4'h4, per(3, 2));
      bw(4'h0, cw(15, 1, 1, 0));
      @(negedge clk); @(negedge clk);
      bw(4'h0, cw(15, 1, 0, 0));
      for (int j = 0; j < 3; j++) begin
         chk({31'd0, pwm_out[0]}, 32'd1, "R6 gate off idle");
         @(negedge clk);
      end
      bw(4'h0, cw(15, 1, 1, 0));
      for (int k = 0; k < 8; k++) begin
         chk({31'd0, pwm_out[0]}, {31'd0, exp_out(k, 1, 3, 2, 0)}, "R6 restart from zero");
         @(negedge clk);
      end
      bw(4'h0, cw(15, 0, 1, 0));
      for (int j = 0; j < 3; j++) begin
         chk({31'd0, pwm_out[0]}, 32'd1, "R6 enable off idle");
         @(negedge clk);
      end

      // R8 reserved codes hold the count
      bw(4'h0, 32'h0);
      bw(4'h4, per(3, 3));
      bw(4'h0, cw(15, 1, 1, 1));
      @(negedge clk);
      bw(4'h0, cw(5, 1, 1, 1));
      for (int j = 0; j < 3; j++) begin
         chk({31'd0, pwm_out[0]}, 32'd0, "R8 reserved code 5 idle");
         @(negedge clk);
      end
      bw(4'h0, cw(13, 1, 1, 1));
      chk({31'd0, pwm_out[0]}, 32'd0, "R8 reserved code 13 idle");
      bw(4'h0, cw(15, 1, 1, 1));
      for (int j = 0; j < 8; j++) begin
         chk({31'd0, pwm_out[0]}, {31'd0, exp_out(2 + j, 1, 3, 3, 1)}, "R8 resume from held count");
         @(negedge clk);
      end

      // R9 R10 running update and dropped write
      bw(4'h0, 32'h0);
      bw(4'h4, per(3, 1));
      bw(4'h0, cw(15, 1, 1, 1));
      @(negedge clk);
      bw(4'h4, per(1, 2));
      br(4'h0, rd); chk({31'd0, rd[28]}, 32'd1, "R9 busy while pending");
      chk({31'd0, pwm_out[0]}, 32'd0, "R9 old duty before wrap");
      bw(4'h4, per(0, 0));
      br(4'h0, rd); chk({31'd0, rd[28]}, 32'd1, "R10 busy still set");
      chk({31'd0, pwm_out[0]}, 32'd0, "R10 old duty kept");
      @(negedge clk);
      br(4'h0, rd); chk({31'd0, rd[28]}, 32'd0, "R9 busy cleared at wrap");
      br(4'h4, rd); chk(rd, 32'h0001_0002, "R10 dropped write not stored");
      for (int j = 0; j < 4; j++) begin
         chk({31'd0, pwm_out[0]}, 32'd1, "R9 new duty after wrap");
         @(negedge clk);
      end

      // R11 write lands on a wrap edge
      bw(4'h0, 32'h0);
      bw(4'h4, per(1, 1));
      bw(4'h0, cw(15, 1, 1, 1));
      @(negedge clk);
      bw(4'h4, per(2, 0));
      br(4'h0, rd); chk({31'd0, rd[28]}, 32'd1, "R11 busy after wrap-edge write");
      chk({31'd0, pwm_out[0]}, 32'd1, "R11 old duty one more period");
      @(negedge clk);
      br(4'h0, rd); chk({31'd0, rd[28]}, 32'd1, "R11 busy held");
      chk({31'd0, pwm_out[0]}, 32'd0, "R11 old duty low phase");
      @(negedge clk);
      br(4'h0, rd); chk({31'd0, rd[28]}, 32'd0, "R11 busy cleared next wrap");
      br(4'h4, rd); chk(rd, 32'h0002_0000, "R11 pending value stored");
      for (int j = 0; j < 4; j++) begin
         chk({31'd0, pwm_out[0]}, 32'd0, "R11 new duty applied");
         @(negedge clk);
      end

      // R7 divider table
      for (int i = 0; i < 7; i++) begin
         bw(4'h0, 32'h0);
         bw(4'h4, per(1, 1));
         bw(4'h0, cw(codes[i], 1, 1, 1));
         repeat (ratios[i] - 1) @(negedge clk);
         chk({31'd0, pwm_out[0]}, 32'd1, $sformatf("R7 code %0d before step", codes[i]));
         @(negedge clk);
         chk({31'd0, pwm_out[0]}, 32'd0, $sformatf("R7 code %0d at step", codes[i]));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule